// File: doc/BRIEF.md
# Linked-List Descriptor Transmit Queue

This block is the transmit DMA controller for one queue. It walks a chain of descriptors kept in memory. Software loads the address of the first descriptor into a queue pointer register and then strobes an enable. The controller fetches each descriptor one word at a time and issues a request for the frame data it names. It then writes a done status back into the descriptor, pulses a completion strobe and follows the descriptor's link word to the next one. The chain ends at a zero link or at a descriptor whose end-of-list flag is set. The queue then halts with the pointer still naming the last descriptor it sent.

New work is never started by rewriting the pointer. The pointer register accepts a write only while it holds zero. Software instead appends a frame by storing its address into the link word of the last completed descriptor, and then strobes enable again. On this restart the controller reads the link word of the descriptor at the pointer again and resumes from that address. If the link is still zero, it halts again without sending anything.

Each descriptor is four 32-bit words at byte offsets 0, 4, 8 and 12:
- offset 0: the link address.
- offset 4: the buffer address.
- offset 8: the control word. Bits [15:0] hold the buffer length and bit 31 is the end-of-list flag.
- offset 12: the status word. The controller writes it with bit 31 set.

Top module: `txq_chain_walker`

## Requirements
- R1: After reset the pointer output is zero, busy is low, and no read, payload or write request is valid.
- R2: A pointer write takes effect only while the pointer is zero. A write while the pointer is non-zero leaves the pointer output unchanged.
- R3: When enable is strobed after a fresh pointer write, the controller reads the descriptor words at pointer+0, +4 and +8 in that order. It never has a read request valid while an earlier read is still waiting for its response.
- R4: For each descriptor, the payload request carries the buffer address from word 1 and the length from word 2 bits [15:0]. Address and length are held stable while the request waits for ready.
- R5: After the payload request is accepted, the controller writes 0x8000_0000 to descriptor+12. It then raises the completion strobe for exactly one cycle, with the completion address equal to the descriptor address.
- R6: When a completed descriptor has a non-zero link and its end-of-list flag (word 2 bit 31) is clear, the pointer moves to the link and that descriptor is transmitted next.
- R7: A zero link or a set end-of-list flag halts the queue (busy low). The pointer keeps the address of the last transmitted descriptor, and no later descriptor is read.
- R8: An enable strobe while halted, with the pointer non-zero and already transmitted, first reads word 0 at the pointer. A non-zero value becomes the new pointer and transmission resumes there.
- R9: If that restart read returns zero, the queue halts again with no payload request, no completion and an unchanged pointer.
- R10: An enable strobe while busy, or while the pointer is zero, has no effect.
- R11: Busy is high from the cycle after an accepted enable until the queue halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_ptr_wr | input | 1 | Pointer register write strobe |
| sw_ptr_data | input | AW | Pointer write value |
| sw_enable | input | 1 | Queue enable strobe |
| q_ptr | output | AW | Current pointer register |
| q_busy | output | 1 | High while the queue is walking its chain |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory read request accepted |
| rd_addr | output | AW | Memory read byte address |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | AW | Read response word |
| pay_valid | output | 1 | Frame data request valid |
| pay_ready | input | 1 | Frame data request accepted |
| pay_addr | output | AW | Frame buffer address |
| pay_len | output | LW | Frame buffer length |
| wr_valid | output | 1 | Status write valid |
| wr_ready | input | 1 | Status write accepted |
| wr_addr | output | AW | Status write byte address |
| wr_data | output | AW | Status write word |
| cmpl | output | 1 | One-cycle descriptor completion strobe |
| cmpl_addr | output | AW | Address of the completed descriptor |

## Verification
The hardest case to reach is a restart after a halt. It needs a completed chain, then a memory update made behind the controller's back, then a pointer write that must be dropped, and only then an enable. The stimulus runs a two-descriptor chain to its zero link and restarts once while the link is still zero. It then patches that link to a new end-of-list descriptor, tries to overwrite the pointer, and restarts again. The order of the read addresses shows that the old descriptor was read again and that nothing beyond the end-of-list descriptor was fetched.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [2:0] {
    S_HALT, S_RELINK, S_LINK, S_BUF, S_CTL, S_PAY, S_WB, S_DONE
  } txq_state_t;
  localparam int OFF_LINK = 0;
  localparam int OFF_BUF  = 4;
  localparam int OFF_CTL  = 8;
  localparam int OFF_STAT = 12;
  localparam int EOL_BIT  = 31;
  localparam int DONE_BIT = 31;
endpackage

// File: rtl/txq_ptr_reg.sv
module txq_ptr_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_wr,
  input  logic [AW-1:0] sw_data,
  input  logic          adv,
  input  logic [AW-1:0] adv_addr,
  input  logic          take,
  output logic [AW-1:0] ptr,
  output logic          fresh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      fresh <= 1'b0;
    end else begin
      if (adv) begin
        ptr <= adv_addr;
      end else if (sw_wr && ptr == '0) begin
        ptr   <= sw_data;
        fresh <= (sw_data != '0);
      end
      if (take) fresh <= 1'b0;
    end
  end

  a_r2_locked_ptr: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && ptr != '0 && !adv) |=> ptr == $past(ptr));
endmodule

// File: rtl/txq_walker_fsm.sv
module txq_walker_fsm
  import txq_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_enable,
  input  logic [AW-1:0] ptr,
  input  logic          fresh,
  output logic          adv,
  output logic [AW-1:0] adv_addr,
  output logic          take,
  output logic          busy,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_data,
  output logic          pay_valid,
  input  logic          pay_ready,
  output logic [AW-1:0] pay_addr,
  output logic [LW-1:0] pay_len,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] wr_data,
  output logic          cmpl,
  output logic [AW-1:0] cmpl_addr
);
  txq_state_t    st;
  logic          pend;
  logic [AW-1:0] link_q;
  logic [AW-1:0] buf_q;
  logic [LW-1:0] len_q;
  logic          eol_q;
  logic          rd_state;
  logic          got;
  logic          last;
  logic          start;

  assign rd_state = (st == S_RELINK) || (st == S_LINK) || (st == S_BUF) || (st == S_CTL);
  assign rd_valid = rd_state && !pend;
  assign got      = pend && rsp_valid;
  assign last     = (link_q == '0) || eol_q;
  assign start    = (st == S_HALT) && sw_enable && (ptr != '0);
  assign take     = start;
  assign busy     = (st != S_HALT);

  always_comb begin
    case (st)
      S_BUF:   rd_addr = ptr + AW'(OFF_BUF);
      S_CTL:   rd_addr = ptr + AW'(OFF_CTL);
      default: rd_addr = ptr + AW'(OFF_LINK);
    endcase
  end

  always_comb begin
    adv      = 1'b0;
    adv_addr = link_q;
    if (st == S_RELINK && got && rsp_data != '0) begin
      adv      = 1'b1;
      adv_addr = rsp_data;
    end else if (st == S_DONE && !last) begin
      adv = 1'b1;
    end
  end

  assign pay_valid = (st == S_PAY);
  assign pay_addr  = buf_q;
  assign pay_len   = len_q;
  assign wr_valid  = (st == S_WB);
  assign wr_addr   = ptr + AW'(OFF_STAT);
  assign wr_data   = AW'(1) << DONE_BIT;
  assign cmpl      = (st == S_DONE);
  assign cmpl_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_HALT;
      pend   <= 1'b0;
      link_q <= '0;
      buf_q  <= '0;
      len_q  <= '0;
      eol_q  <= 1'b0;
    end else begin
      if (rd_valid && rd_ready) pend <= 1'b1;
      if (got) pend <= 1'b0;
      case (st)
        S_HALT:   if (start) st <= fresh ? S_LINK : S_RELINK;
        S_RELINK: if (got) st <= (rsp_data != '0) ? S_LINK : S_HALT;
        S_LINK:   if (got) begin link_q <= rsp_data; st <= S_BUF; end
        S_BUF:    if (got) begin buf_q <= rsp_data; st <= S_CTL; end
        S_CTL:    if (got) begin
                    len_q <= rsp_data[LW-1:0];
                    eol_q <= rsp_data[EOL_BIT];
                    st    <= S_PAY;
                  end
        S_PAY:    if (pay_ready) st <= S_WB;
        S_WB:     if (wr_ready) st <= S_DONE;
        S_DONE:   st <= last ? S_HALT : S_LINK;
        default:  st <= S_HALT;
      endcase
    end
  end

  a_r5_cmpl_single: assert property (@(posedge clk) disable iff (rst)
    cmpl |=> !cmpl);
  a_r4_pay_hold: assert property (@(posedge clk) disable iff (rst)
    (pay_valid && !pay_ready) |=> pay_valid && $stable(pay_addr) && $stable(pay_len));
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_addr));
endmodule

// File: rtl/txq_chain_walker.sv
module txq_chain_walker #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_ptr_wr,
  input  logic [AW-1:0] sw_ptr_data,
  input  logic          sw_enable,
  output logic [AW-1:0] q_ptr,
  output logic          q_busy,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_data,
  output logic          pay_valid,
  input  logic          pay_ready,
  output logic [AW-1:0] pay_addr,
  output logic [LW-1:0] pay_len,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] wr_data,
  output logic          cmpl,
  output logic [AW-1:0] cmpl_addr
);
  logic          adv;
  logic [AW-1:0] adv_addr;
  logic          take;
  logic          fresh;

  txq_ptr_reg #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .sw_wr(sw_ptr_wr), .sw_data(sw_ptr_data),
    .adv(adv), .adv_addr(adv_addr), .take(take), .ptr(q_ptr), .fresh(fresh)
  );

  txq_walker_fsm #(.AW(AW), .LW(LW)) u_fsm (
    .clk(clk), .rst(rst), .sw_enable(sw_enable), .ptr(q_ptr), .fresh(fresh),
    .adv(adv), .adv_addr(adv_addr), .take(take), .busy(q_busy),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_addr(pay_addr), .pay_len(pay_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmpl(cmpl), .cmpl_addr(cmpl_addr)
  );

  a_r7_hold_on_halt: assert property (@(posedge clk) disable iff (rst)
    $fell(q_busy) |-> $stable(q_ptr));
endmodule

// File: tb/sim_txq_chain_walker.sv
module sim_txq_chain_walker;
  localparam int AW = 32;
  localparam int LW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, sw_ptr_wr, sw_enable;
  logic [AW-1:0] sw_ptr_data;
  logic [AW-1:0] q_ptr, rd_addr, rsp_data, pay_addr, wr_addr, wr_data, cmpl_addr;
  logic q_busy, rd_valid, rd_ready, rsp_valid, pay_valid, pay_ready, wr_valid, wr_ready, cmpl;
  logic [LW-1:0] pay_len;

  txq_chain_walker #(.AW(AW), .LW(LW)) u0 (
    .clk(clk), .rst(rst), .sw_ptr_wr(sw_ptr_wr), .sw_ptr_data(sw_ptr_data),
    .sw_enable(sw_enable), .q_ptr(q_ptr), .q_busy(q_busy),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_addr(pay_addr), .pay_len(pay_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmpl(cmpl), .cmpl_addr(cmpl_addr)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int overlap = 0;
  int cyc = 0;

  logic [31:0] mem [256];
  logic [31:0] rd_log [$];
  logic [31:0] exp_cmpl [$];
  logic [31:0] exp_pay [$];
  int n_cmpl = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_ready  <= (cyc % 3) != 1;
    pay_ready <= (cyc % 4) != 0;
    wr_ready  <= (cyc % 2) == 0;
    rsp_valid <= 1'b0;
    if (rd_valid && rd_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= mem[rd_addr[9:2]];
    end
    if (wr_valid && wr_ready) mem[wr_addr[9:2]] <= wr_data;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid && rsp_valid) overlap++;
      if (rd_valid && rd_ready) rd_log.push_back(rd_addr);
      if (pay_valid && pay_ready) begin
        if (exp_pay.size() < 2) check(0, "R4 unexpected payload", pay_addr, 0);
        else begin
          logic [31:0] ea, el;
          ea = exp_pay.pop_front();
          el = exp_pay.pop_front();
          check(pay_addr == ea && 32'(pay_len) == el, "R4 payload", pay_addr ^ 32'(pay_len), ea ^ el);
        end
      end
      if (cmpl) begin
        n_cmpl++;
        if (exp_cmpl.size() == 0) check(0, "R5 unexpected completion", cmpl_addr, 0);
        else begin
          logic [31:0] e;
          e = exp_cmpl.pop_front();
          check(cmpl_addr == e, "R5 completion addr", cmpl_addr, e);
        end
      end
    end
  end

  task automatic desc(input logic [31:0] a, input logic [31:0] lnk, input logic [31:0] b,
                      input logic [15:0] len, input bit eol);
    mem[a[9:2]]     = lnk;
    mem[a[9:2] + 1] = b;
    mem[a[9:2] + 2] = {eol, 15'd0, len};
    mem[a[9:2] + 3] = 32'h0;
  endtask

  task automatic ptr_write(input logic [31:0] v);
    @(negedge clk); sw_ptr_wr = 1; sw_ptr_data = v;
    @(negedge clk); sw_ptr_wr = 0;
  endtask

  task automatic pulse_en();
    @(negedge clk); sw_enable = 1;
    @(negedge clk); sw_enable = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (q_busy && n < 2000) begin @(negedge clk); n++; end
    check(!q_busy, "R7 halt reached", 32'(q_busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    rst = 1; sw_ptr_wr = 0; sw_enable = 0; sw_ptr_data = 0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(q_ptr == 0, "R1 ptr zero", q_ptr, 0);
    check(!q_busy && !rd_valid && !pay_valid && !wr_valid, "R1 idle",
          {q_busy, rd_valid, pay_valid, wr_valid}, 0);

    desc(32'h40, 32'h60, 32'h1000, 16'd100, 0);
    desc(32'h60, 32'h0,  32'h2000, 16'd200, 0);
    desc(32'hA0, 32'hC0, 32'h3000, 16'd300, 1);
    desc(32'hC0, 32'h0,  32'h4000, 16'd400, 0);

    ptr_write(32'h40);
    @(negedge clk);
    check(q_ptr == 32'h40, "R2 first write taken", q_ptr, 32'h40);
    ptr_write(32'h80);
    @(negedge clk);
    check(q_ptr == 32'h40, "R2 second write ignored", q_ptr, 32'h40);

    exp_pay.push_back(32'h1000); exp_pay.push_back(100);
    exp_pay.push_back(32'h2000); exp_pay.push_back(200);
    exp_cmpl.push_back(32'h40); exp_cmpl.push_back(32'h60);
    rd_log.delete();
    pulse_en();
    check(q_busy, "R11 busy after enable", 32'(q_busy), 1);
    pulse_en(); // R10 enable while running is ignored
    wait_idle();
    repeat (2) @(negedge clk);
    check(rd_log.size() >= 3 && rd_log[0] == 32'h40 && rd_log[1] == 32'h44 && rd_log[2] == 32'h48,
          "R3 word order", rd_log.size() >= 3 ? rd_log[2] : 0, 32'h48);
    check(rd_log.size() == 6, "R6 R10 second descriptor only", rd_log.size(), 6);
    check(q_ptr == 32'h60, "R7 ptr at last sent", q_ptr, 32'h60);
    check(mem[(32'h40 + 12) >> 2] == 32'h8000_0000 && mem[(32'h60 + 12) >> 2] == 32'h8000_0000,
          "R5 status writeback", mem[(32'h60 + 12) >> 2], 32'h8000_0000);
    check(exp_cmpl.size() == 0 && exp_pay.size() == 0, "R6 all items seen",
          exp_cmpl.size() + exp_pay.size(), 0);

    // R9 restart with link still zero
    c0 = n_cmpl;
    rd_log.delete();
    pulse_en();
    wait_idle();
    repeat (2) @(negedge clk);
    check(n_cmpl == c0, "R9 no completion", n_cmpl, c0);
    check(q_ptr == 32'h60, "R9 ptr unchanged", q_ptr, 32'h60);
    check(rd_log.size() == 1 && rd_log[0] == 32'h60, "R9 single reread", rd_log.size(), 1);

    // R8 append via link of the last completed descriptor
    mem[32'h60 >> 2] = 32'hA0;
    ptr_write(32'h100);
    @(negedge clk);
    check(q_ptr == 32'h60, "R2 write ignored while halted", q_ptr, 32'h60);
    exp_pay.push_back(32'h3000); exp_pay.push_back(300);
    exp_cmpl.push_back(32'hA0);
    rd_log.delete();
    pulse_en();
    wait_idle();
    repeat (2) @(negedge clk);
    check(rd_log.size() == 4 && rd_log[0] == 32'h60 && rd_log[1] == 32'hA0,
          "R8 reread then resume", rd_log.size() >= 2 ? rd_log[1] : 0, 32'hA0);
    check(q_ptr == 32'hA0, "R7 end-of-list halt ptr", q_ptr, 32'hA0);
    check(exp_cmpl.size() == 0, "R8 completion seen", exp_cmpl.size(), 0);

    check(overlap == 0, "R3 one outstanding read", overlap, 0);

    // R10 enable with zero pointer after reset
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    pulse_en();
    @(negedge clk);
    check(!q_busy && !rd_valid, "R10 zero pointer enable ignored", 32'(q_busy), 0);
    check(q_ptr == 0, "R1 ptr cleared by reset", q_ptr, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule